// File: doc/BRIEF.md
# Byte Transfer Buffer with Remaining-Count Tracking

This block sits between a register bus and a serial bus protocol engine and carries the data bytes of one transaction. A single byte FIFO (16 entries by default) is filled from the register side and drained by the engine when transmitting. When receiving, the engine fills it and the register side drains it. A transfer-size counter tracks how many bytes of a receive remain. In transmit mode the same readback shows how many bytes are queued, so software computes free space as depth minus that value.

Software picks the direction and may strobe a FIFO clear. It may also set a hold control. While hold is set, the block asks the engine to stall the bus instead of ending the transfer, whenever the FIFO cannot keep up. A transmit FIFO with nothing to send stalls the bus, and so does a full receive FIFO. This lets software refill or drain the FIFO, and keeps the bus for a repeated start.

The block raises one-cycle event pulses:
- a data-threshold event when the receive FIFO reaches depth minus two;
- a completion event;
- transmit overflow, receive overflow and receive underflow events.

Engine-side transfers use valid/ready. A transmit byte moves when `eng_tx_valid` and `eng_tx_ready` are both high at a clock edge. `eng_tx_valid` and `eng_tx_data` hold until that byte is taken. A received byte is accepted when `eng_rx_valid` and `eng_rx_ready` are both high. An engine that presents `eng_rx_valid` while `eng_rx_ready` is low loses that byte and an overflow is flagged.

Top module: `byte_xfer_buffer`

## Requirements
- R1: After reset the FIFO is empty; `xsz_value`, `rx_avail`, `eng_tx_valid`, `bus_stall` and all event outputs are 0.
- R2: With `ctl_dir`=0 (transmit), each `wr_strobe` pushes `wr_data`. The engine receives the bytes on `eng_tx_data` in write order. `xsz_value` shows the number of bytes queued (0 to 16).
- R3: A `wr_strobe` while 16 bytes are held drops the byte, leaves the queue unchanged, and pulses `ev_tx_ovf` for one cycle after that edge.
- R4: With `ctl_dir`=1 (receive), a `rd_strobe` while the FIFO is empty sees `rd_data`=0 and pulses `ev_rx_unf` for one cycle after that edge.
- R5: A received byte offered while the FIFO holds 16 bytes is dropped. It pulses `ev_rx_ovf` and leaves the remaining count unchanged.
- R6: In receive mode, a received byte that raises the fill level from 13 to 14 (depth minus two) pulses `ev_thresh` for one cycle.
- R7: In receive mode, `xsz_value` shows the remaining count. `xsz_load` sets it to `xsz_wdata` (0 to 255). Each accepted received byte decrements it, and it stays at 0 once there.
- R8: In receive mode, the accepted byte that brings the remaining count from 1 to 0 pulses `ev_done`. Further bytes at count 0 do not.
- R9: In transmit mode, an engine transfer that empties the FIFO pulses `ev_done`, whatever the hold setting.
- R10: A `ctl_clear` strobe empties the FIFO at that edge. Writes, reads and engine transfers in the same cycle are discarded and raise no event.
- R11: `bus_stall` is high when `ctl_hold` is set and either the FIFO is empty in transmit mode or it is full in receive mode.
- R12: In receive mode, `rx_avail` is high while unread bytes remain. Register writes in receive mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_dir | input | 1 | Direction: 0 transmit, 1 receive |
| ctl_hold | input | 1 | Keep the bus instead of ending the transfer |
| ctl_clear | input | 1 | One-cycle strobe that empties the FIFO |
| wr_strobe | input | 1 | Data-register write strobe |
| wr_data | input | 8 | Byte to queue for transmit |
| rd_strobe | input | 1 | Data-register read strobe (pops in receive mode) |
| rd_data | output | 8 | Oldest received byte, 0 when none |
| xsz_load | input | 1 | Load the transfer-size counter |
| xsz_wdata | input | 8 | Value to load |
| xsz_value | output | 8 | Remaining count (receive) or queued bytes (transmit) |
| eng_tx_valid | output | 1 | A byte is ready for the engine |
| eng_tx_ready | input | 1 | Engine takes the byte |
| eng_tx_data | output | 8 | Byte offered to the engine |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | FIFO can accept a received byte |
| eng_rx_data | input | 8 | Received byte |
| bus_stall | output | 1 | Request to stall the bus |
| rx_avail | output | 1 | Unread received bytes present |
| ev_thresh | output | 1 | Receive fill reached depth minus two |
| ev_done | output | 1 | Transfer completion pulse |
| ev_tx_ovf | output | 1 | Write to a full FIFO |
| ev_rx_ovf | output | 1 | Received byte lost to a full FIFO |
| ev_rx_unf | output | 1 | Read of an empty FIFO |

## Verification
The bench builds the block with its default parameters: a 16-byte FIFO, a threshold gap of two and an 8-bit counter. With these values, full, overflow and the 13-to-14 threshold crossing are reached within a few dozen strobes. The 8-bit counter lets a full-range load of 255 be read back. A single receive sequence also walks the remaining count through overflow, drain and its final decrement to zero.

// File: rtl/bxb_pkg.sv
package bxb_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } bxb_dir_e;

  typedef struct packed {
    logic thresh;
    logic done;
    logic tx_ovf;
    logic rx_ovf;
    logic rx_unf;
  } bxb_evt_t;
endpackage

// File: rtl/bxb_fifo.sv
module bxb_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [FW-1:0] fill,
  output logic          empty,
  output logic          full
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign empty = (fill == '0);
  assign full  = (fill == FW'(DEPTH));
endmodule

// File: rtl/bxb_remain.sv
module bxb_remain #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   value <= '0;
    else if (load)                value <= load_val;
    else if (dec && value != '0)  value <= value - 1'b1;
  end
endmodule

// File: rtl/bxb_events.sv
module bxb_events
  import bxb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bxb_evt_t evt_next,
  output bxb_evt_t evt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_next;
  end
endmodule

// File: rtl/byte_xfer_buffer.sv
module byte_xfer_buffer
  import bxb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int CW         = 8,
  parameter int THRESH_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_dir,
  input  logic          ctl_hold,
  input  logic          ctl_clear,
  input  logic          wr_strobe,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_strobe,
  output logic [DW-1:0] rd_data,
  input  logic          xsz_load,
  input  logic [CW-1:0] xsz_wdata,
  output logic [CW-1:0] xsz_value,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_valid,
  output logic          eng_rx_ready,
  input  logic [DW-1:0] eng_rx_data,
  output logic          bus_stall,
  output logic          rx_avail,
  output logic          ev_thresh,
  output logic          ev_done,
  output logic          ev_tx_ovf,
  output logic          ev_rx_ovf,
  output logic          ev_rx_unf
);
  localparam int FW         = $clog2(DEPTH + 1);
  localparam int THRESH_LVL = DEPTH - THRESH_GAP;

  logic          rx_mode;
  logic [DW-1:0] head;
  logic [FW-1:0] fill_lvl;
  logic          empty, full;
  logic          wr_ok, wr_drop, eng_pop, rd_ok, rd_unf;
  logic          rx_in, rx_ok, rx_drop;
  logic          push, pop;
  logic [DW-1:0] push_data;
  logic [CW-1:0] remain;
  bxb_evt_t      evt_next, evt_q;

  assign rx_mode = (bxb_dir_e'(ctl_dir) == DIR_RX);

  // Qualified transfers; a clear strobe wins over everything else
  assign wr_ok   = !rx_mode && wr_strobe && !full  && !ctl_clear;
  assign wr_drop = !rx_mode && wr_strobe &&  full  && !ctl_clear;
  assign eng_pop = eng_tx_valid && eng_tx_ready && !ctl_clear;
  assign rd_ok   =  rx_mode && rd_strobe && !empty && !ctl_clear;
  assign rd_unf  =  rx_mode && rd_strobe &&  empty && !ctl_clear;
  assign rx_in   =  rx_mode && eng_rx_valid && !ctl_clear;
  assign rx_ok   = rx_in && !full;
  assign rx_drop = rx_in &&  full;

  assign push      = wr_ok | rx_ok;
  assign pop       = eng_pop | rd_ok;
  assign push_data = rx_mode ? eng_rx_data : wr_data;

  bxb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_clear),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .fill      (fill_lvl),
    .empty     (empty),
    .full      (full)
  );

  bxb_remain #(.CW(CW)) u_remain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xsz_load),
    .load_val (xsz_wdata),
    .dec      (rx_ok),
    .value    (remain)
  );

  always_comb begin
    evt_next        = '0;
    evt_next.thresh = rx_ok && !rd_ok && (fill_lvl == FW'(THRESH_LVL - 1));
    evt_next.done   = (rx_ok && !xsz_load && remain == CW'(1)) ||
                      (eng_pop && !wr_ok && fill_lvl == FW'(1));
    evt_next.tx_ovf = wr_drop;
    evt_next.rx_ovf = rx_drop;
    evt_next.rx_unf = rd_unf;
  end

  bxb_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_next (evt_next),
    .evt_q    (evt_q)
  );

  assign eng_tx_valid = !rx_mode && !empty;
  assign eng_tx_data  = head;
  assign eng_rx_ready = rx_mode && !full;
  assign rd_data      = (rx_mode && !empty) ? head : '0;
  assign rx_avail     = rx_mode && !empty;
  assign xsz_value    = rx_mode ? remain : CW'(fill_lvl);
  assign bus_stall    = ctl_hold && (rx_mode ? full : empty);

  assign ev_thresh = evt_q.thresh;
  assign ev_done   = evt_q.done;
  assign ev_tx_ovf = evt_q.tx_ovf;
  assign ev_rx_ovf = evt_q.rx_ovf;
  assign ev_rx_unf = evt_q.rx_unf;
endmodule

// File: rtl/bxb_chk.sv
module bxb_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_dir,
  input logic          ctl_clear,
  input logic          wr_strobe,
  input logic          rd_strobe,
  input logic          xsz_load,
  input logic          eng_tx_valid,
  input logic          eng_tx_ready,
  input logic [DW-1:0] eng_tx_data,
  input logic          ev_done,
  input logic          ev_tx_ovf,
  input logic [CW-1:0] xsz_value,
  input logic [FW-1:0] fill_lvl
);
  // R3
  tx_ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_ovf |-> ($past(wr_strobe) && $past(fill_lvl) == FW'(DEPTH)));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_clear) |-> fill_lvl == '0);

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl > $past(fill_lvl)) |-> (fill_lvl == $past(fill_lvl) + 1'b1));

  // R8
  rx_done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && ctl_dir && $past(ctl_dir) && !$past(xsz_load)) |-> xsz_value == '0);

  // R2
  tx_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready && !ctl_clear && !rd_strobe) |=> $stable(eng_tx_data));
endmodule

bind byte_xfer_buffer bxb_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_dir      (ctl_dir),
  .ctl_clear    (ctl_clear),
  .wr_strobe    (wr_strobe),
  .rd_strobe    (rd_strobe),
  .xsz_load     (xsz_load),
  .eng_tx_valid (eng_tx_valid),
  .eng_tx_ready (eng_tx_ready),
  .eng_tx_data  (eng_tx_data),
  .ev_done      (ev_done),
  .ev_tx_ovf    (ev_tx_ovf),
  .xsz_value    (xsz_value),
  .fill_lvl     (fill_lvl)
);

// File: tb/byte_xfer_buffer_tb.sv
module byte_xfer_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_dir = 1'b0, ctl_hold = 1'b0, ctl_clear = 1'b0;
  logic       wr_strobe = 1'b0, rd_strobe = 1'b0, xsz_load = 1'b0;
  logic [7:0] wr_data = '0, xsz_wdata = '0, eng_rx_data = '0;
  logic       eng_tx_ready = 1'b0, eng_rx_valid = 1'b0;
  logic [7:0] rd_data, xsz_value, eng_tx_data;
  logic       eng_tx_valid, eng_rx_ready, bus_stall, rx_avail;
  logic       ev_thresh, ev_done, ev_tx_ovf, ev_rx_ovf, ev_rx_unf;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  byte_xfer_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_dir(ctl_dir), .ctl_hold(ctl_hold),
    .ctl_clear(ctl_clear), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .xsz_load(xsz_load),
    .xsz_wdata(xsz_wdata), .xsz_value(xsz_value), .eng_tx_valid(eng_tx_valid),
    .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
    .eng_rx_data(eng_rx_data), .bus_stall(bus_stall), .rx_avail(rx_avail),
    .ev_thresh(ev_thresh), .ev_done(ev_done), .ev_tx_ovf(ev_tx_ovf),
    .ev_rx_ovf(ev_rx_ovf), .ev_rx_unf(ev_rx_unf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock edge; returns at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] b);
    wr_strobe = 1'b1; wr_data = b;
    step();
    wr_strobe = 1'b0;
  endtask

  task automatic eng_take();
    eng_tx_ready = 1'b1;
    step();
    eng_tx_ready = 1'b0;
  endtask

  task automatic eng_give(input logic [7:0] b);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    step();
    eng_rx_valid = 1'b0;
  endtask

  task automatic host_read();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
  endtask

  task automatic do_clear();
    ctl_clear = 1'b1;
    step();
    ctl_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 xsz_value", xsz_value, 0);
    check("R1 rx_avail", rx_avail, 0);
    check("R1 eng_tx_valid", eng_tx_valid, 0);
    check("R1 bus_stall", bus_stall, 0);
    check("R1 events", {ev_thresh, ev_done, ev_tx_ovf, ev_rx_ovf, ev_rx_unf}, 0);
  endtask

  task automatic t_tx_order();
    ctl_dir = 1'b0;
    host_write(8'hA1); host_write(8'hB2); host_write(8'hC3);
    check("R2 queued count", xsz_value, 3);
    check("R2 tx valid", eng_tx_valid, 1);
    check("R2 first byte", eng_tx_data, 8'hA1);
    eng_take();
    check("R2 second byte", eng_tx_data, 8'hB2);
    check("R9 no early done", ev_done, 0);
    eng_take();
    check("R2 third byte", eng_tx_data, 8'hC3);
    eng_take();
    check("R9 done on empty", ev_done, 1);
    check("R2 queue empty", xsz_value, 0);
    step();
    check("R9 done one cycle", ev_done, 0);
  endtask

  task automatic t_tx_full();
    ctl_dir = 1'b0; ctl_hold = 1'b1;
    step();
    check("R11 stall tx empty", bus_stall, 1);
    for (int i = 0; i < 16; i++) host_write(8'(i + 8'h10));
    check("R11 no stall with data", bus_stall, 0);
    check("R2 sixteen queued", xsz_value, 16);
    check("R3 no early ovf", ev_tx_ovf, 0);
    host_write(8'hEE);
    check("R3 ovf pulse", ev_tx_ovf, 1);
    check("R3 count kept", xsz_value, 16);
    for (int i = 0; i < 16; i++) begin
      check("R3 order after drop", eng_tx_data, i + 8'h10);
      eng_take();
    end
    check("R9 done with hold", ev_done, 1);
    check("R3 dropped byte absent", eng_tx_valid, 0);
    ctl_hold = 1'b0;
    step();
  endtask

  task automatic t_underflow();
    ctl_dir = 1'b1;
    do_clear();
    check("R4 empty read zero", rd_data, 0);
    host_read();
    check("R4 unf pulse", ev_rx_unf, 1);
    step();
    check("R4 unf one cycle", ev_rx_unf, 0);
  endtask

  task automatic t_rx();
    ctl_dir = 1'b1;
    do_clear();
    host_write(8'h77);
    check("R12 write ignored in rx", rx_avail, 0);
    xsz_load = 1'b1; xsz_wdata = 8'd20;
    step();
    xsz_load = 1'b0;
    check("R7 load", xsz_value, 20);
    for (int i = 0; i < 13; i++) eng_give(8'(8'h40 + i));
    check("R6 no thresh at 13", ev_thresh, 0);
    check("R12 rx_avail", rx_avail, 1);
    eng_give(8'h4D);
    check("R6 thresh at 14", ev_thresh, 1);
    check("R7 decremented", xsz_value, 6);
    eng_give(8'h4E); eng_give(8'h4F);
    check("R6 thresh one-shot", ev_thresh, 0);
    check("R7 after 16", xsz_value, 4);
    ctl_hold = 1'b1;
    step();
    check("R11 stall rx full", bus_stall, 1);
    check("R5 ready low when full", eng_rx_ready, 0);
    eng_give(8'h99);
    check("R5 rx ovf", ev_rx_ovf, 1);
    check("R5 count kept", xsz_value, 4);
    for (int i = 0; i < 16; i++) begin
      check("R5 order, dropped byte absent", rd_data, 8'h40 + i);
      host_read();
    end
    check("R12 drained", rx_avail, 0);
    check("R11 stall off when not full", bus_stall, 0);
    ctl_hold = 1'b0;
    for (int i = 0; i < 3; i++) eng_give(8'h60);
    check("R8 no early done", ev_done, 0);
    eng_give(8'h61);
    check("R8 done at zero", ev_done, 1);
    check("R7 zero", xsz_value, 0);
    eng_give(8'h62);
    check("R8 no done past zero", ev_done, 0);
    check("R7 stays zero", xsz_value, 0);
    xsz_load = 1'b1; xsz_wdata = 8'd255;
    step();
    xsz_load = 1'b0;
    check("R7 full-range load", xsz_value, 255);
  endtask

  task automatic t_clear();
    ctl_dir = 1'b0;
    do_clear();
    for (int i = 0; i < 5; i++) host_write(8'(i));
    check("R10 before clear", xsz_value, 5);
    ctl_clear = 1'b1; wr_strobe = 1'b1; wr_data = 8'hCC; eng_tx_ready = 1'b1;
    step();
    ctl_clear = 1'b0; wr_strobe = 1'b0; eng_tx_ready = 1'b0;
    check("R10 emptied", xsz_value, 0);
    check("R10 no tx valid", eng_tx_valid, 0);
    check("R10 no event", {ev_done, ev_tx_ovf}, 0);
    host_write(8'h5A);
    check("R10 reuse after clear", eng_tx_data, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_full();
    t_underflow();
    t_rx();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule